// File: doc/BRIEF.md
# Dropped-Frame Loss Counter

This block keeps two tallies of receive frames that were lost before reaching host memory. One tally counts frames thrown away because the host had no free descriptor to receive them. The other counts frames lost because the receive FIFO overflowed. Each tally saturates at its own maximum and has a sticky flag recording that more losses happened than the tally could hold.

Both tallies and both flags are packed into one 32-bit status word. Host software reads this word periodically to update its statistics. A single-cycle read strobe marks the read. The word shown in that cycle is the value returned, and both tallies and both flags clear on the following edge. A loss that arrives in the same cycle as the read is not lost. It becomes the first count after the clear.

Each tally is a two-state machine. In COUNTING the tally increments on each loss strobe. Taking a strobe while the tally sits at its maximum is the transition COUNTING→PINNED. In PINNED the tally holds its maximum and the flag reads 1. A read strobe in either state is the transition to COUNTING. On that transition the tally becomes 1 if a strobe is present in the same cycle, and 0 otherwise. Reset enters COUNTING with a zero tally.

Top module: `missed_frame_counter`

## Requirements
- R1: After reset the status word is 0x00000000.
- R2: Each cycle with `nodesc_drop_i` high and no read increments the descriptor-loss tally in bits 15:0 by one.
- R3: Each cycle with `fifo_drop_i` high and no read increments the FIFO-loss tally in bits 27:17 by one.
- R4: When both loss strobes are high in the same cycle, both tallies increment.
- R5: A descriptor loss taken while bits 15:0 equal 0xFFFF leaves them at 0xFFFF and sets bit 16.
- R6: A FIFO loss taken while bits 27:17 equal 0x7FF leaves them at 0x7FF and sets bit 28.
- R7: Until a read occurs, a set flag (bit 16 or bit 28) stays set, and a tally at its maximum stays there and does not wrap.
- R8: While `rd_clr_i` is high, the word shows the current tallies and flags. On the next cycle, bits 16:0 and 28:17 read as zero when no loss coincided with the read.
- R9: A loss strobe in the same cycle as a read leaves its tally at 1 and its flag at 0 after the clear.
- R10: Bits 31:29 of the status word always read as zero.
- R11: In a cycle with no loss strobe and no read, the status word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nodesc_drop_i | input | 1 | One-cycle strobe: a frame was dropped for lack of a host descriptor |
| fifo_drop_i | input | 1 | One-cycle strobe: a frame was dropped on receive FIFO overflow |
| rd_clr_i | input | 1 | One-cycle strobe: the status word is being read; clear afterwards |
| status_o | output | 32 | Packed word: [15:0] descriptor-loss tally, [16] its flag, [27:17] FIFO-loss tally, [28] its flag, [31:29] zero |

## Verification
The assertions check the per-cycle rules on every clock:
- a single increment per strobe;
- holding with no strobe;
- no wrap at the maximum;
- flag stickiness;
- a set flag implying a pinned tally;
- the clear-plus-coincident-loss result after a read;
- zero pad bits.

The bench's scenarios show the rest. They drive the full climb of each tally to its maximum and the exact cycle in which each flag rises. They confirm that the value visible during the read cycle is the pre-clear word. They also show that simultaneous strobes on both sources both land in mixed sequences.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
    // Per-tally state: free counting, or pinned at maximum with flag raised
    typedef enum logic {
        ST_COUNTING = 1'b0,
        ST_PINNED   = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/mfc_sat_counter.sv
module mfc_sat_counter
    import mfc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State and tally registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNTING;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state and next-tally logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_COUNTING: begin
                if (clr_i) begin
                    state_d = ST_COUNTING;
                    cnt_d   = evt_i ? CNT_ONE : '0;
                end else if (evt_i) begin
                    if (cnt_q == CNT_MAX) begin
                        state_d = ST_PINNED;
                    end else begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
            end
            ST_PINNED: begin
                if (clr_i) begin
                    state_d = ST_COUNTING;
                    cnt_d   = evt_i ? CNT_ONE : '0;
                end
            end
            default: begin
                state_d = ST_COUNTING;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        count_o = cnt_q;
        flag_o  = (state_q == ST_PINNED);
    end
endmodule

// File: rtl/mfc_word_pack.sv
module mfc_word_pack #(
    parameter int MISS_W = 16,
    parameter int OVF_W  = 11,
    parameter int WORD_W = 32
) (
    input  logic [MISS_W-1:0] miss_cnt_i,
    input  logic              miss_flag_i,
    input  logic [OVF_W-1:0]  ovf_cnt_i,
    input  logic              ovf_flag_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int USED_W = MISS_W + OVF_W + 2;
    localparam int PAD_W  = WORD_W - USED_W;

    logic [USED_W-1:0] used;
    assign used = {ovf_flag_i, ovf_cnt_i, miss_flag_i, miss_cnt_i};

    generate
        if (PAD_W > 0) begin : g_pad
            assign word_o = {{PAD_W{1'b0}}, used};
        end else begin : g_nopad
            assign word_o = used[WORD_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/missed_frame_counter.sv
module missed_frame_counter #(
    parameter int MISS_W = 16,
    parameter int OVF_W  = 11,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nodesc_drop_i,
    input  logic              fifo_drop_i,
    input  logic              rd_clr_i,
    output logic [WORD_W-1:0] status_o
);
    logic [MISS_W-1:0] miss_cnt;
    logic              miss_flag;
    logic [OVF_W-1:0]  ovf_cnt;
    logic              ovf_flag;

    mfc_sat_counter #(.CNT_W(MISS_W)) u_miss_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (nodesc_drop_i),
        .clr_i   (rd_clr_i),
        .count_o (miss_cnt),
        .flag_o  (miss_flag)
    );

    mfc_sat_counter #(.CNT_W(OVF_W)) u_ovf_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (fifo_drop_i),
        .clr_i   (rd_clr_i),
        .count_o (ovf_cnt),
        .flag_o  (ovf_flag)
    );

    mfc_word_pack #(.MISS_W(MISS_W), .OVF_W(OVF_W), .WORD_W(WORD_W)) u_pack (
        .miss_cnt_i  (miss_cnt),
        .miss_flag_i (miss_flag),
        .ovf_cnt_i   (ovf_cnt),
        .ovf_flag_i  (ovf_flag),
        .word_o      (status_o)
    );
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
    parameter int MISS_W = 16,
    parameter int OVF_W  = 11,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nodesc_drop_i,
    input logic              fifo_drop_i,
    input logic              rd_clr_i,
    input logic [WORD_W-1:0] status_o
);
    localparam int MFLAG = MISS_W;
    localparam int OLSB  = MISS_W + 1;
    localparam int OFLAG = OLSB + OVF_W;
    localparam logic [MISS_W-1:0] MMAX = {MISS_W{1'b1}};
    localparam logic [OVF_W-1:0]  OMAX = {OVF_W{1'b1}};

    logic [MISS_W-1:0] m_cnt;
    logic [OVF_W-1:0]  o_cnt;
    logic              m_flg, o_flg;
    assign m_cnt = status_o[MISS_W-1:0];
    assign o_cnt = status_o[OLSB +: OVF_W];
    assign m_flg = status_o[MFLAG];
    assign o_flg = status_o[OFLAG];

    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && nodesc_drop_i && m_cnt != MMAX) |=> m_cnt == MISS_W'($past(m_cnt) + 1'b1)); // R2
    AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && fifo_drop_i && o_cnt != OMAX) |=> o_cnt == OVF_W'($past(o_cnt) + 1'b1)); // R3
    AST_MISS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && nodesc_drop_i && m_cnt == MMAX) |=> (m_cnt == MMAX && m_flg)); // R5
    AST_OVF_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && fifo_drop_i && o_cnt == OMAX) |=> (o_cnt == OMAX && o_flg)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && (m_flg || o_flg)) |=> ((m_flg || !$past(m_flg)) && (o_flg || !$past(o_flg)))); // R7
    AST_FLAG_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_flg || m_cnt == MMAX) && (!o_flg || o_cnt == OMAX)); // R7
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> (m_cnt == MISS_W'($past(nodesc_drop_i)) && o_cnt == OVF_W'($past(fifo_drop_i))
                      && !m_flg && !o_flg)); // R9
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[WORD_W-1:OFLAG+1] == '0); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && !nodesc_drop_i && !fifo_drop_i) |=> $stable(status_o)); // R11
endmodule

bind missed_frame_counter mfc_checker #(.MISS_W(MISS_W), .OVF_W(OVF_W), .WORD_W(WORD_W)) u_mfc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .nodesc_drop_i (nodesc_drop_i),
    .fifo_drop_i   (fifo_drop_i),
    .rd_clr_i      (rd_clr_i),
    .status_o      (status_o)
);

// File: tb/missed_frame_counter_bench.sv
`timescale 1ns/1ps
module missed_frame_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nd = 1'b0, fd = 1'b0, rd = 1'b0;
    logic [31:0] status;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    missed_frame_counter u_missed_frame_counter (
        .clk(clk), .rst_n(rst_n), .nodesc_drop_i(nd), .fifo_drop_i(fd),
        .rd_clr_i(rd), .status_o(status)
    );

    typedef struct packed {
        logic        a;
        logic        b;
        logic        r;
        logic [15:0] m;
        logic [10:0] f;
    } vec_t;

    // Expected tallies after the edge that takes each vector (flags stay 0)
    localparam vec_t VECS [11] = '{
        '{1'b1, 1'b0, 1'b0, 16'd1, 11'd0},  // R2
        '{1'b1, 1'b0, 1'b0, 16'd2, 11'd0},  // R2
        '{1'b0, 1'b1, 1'b0, 16'd2, 11'd1},  // R3
        '{1'b1, 1'b1, 1'b0, 16'd3, 11'd2},  // R4
        '{1'b0, 1'b0, 1'b0, 16'd3, 11'd2},  // R11
        '{1'b0, 1'b0, 1'b1, 16'd0, 11'd0},  // R8
        '{1'b1, 1'b1, 1'b0, 16'd1, 11'd1},  // R4
        '{1'b1, 1'b0, 1'b1, 16'd1, 11'd0},  // R9
        '{1'b0, 1'b1, 1'b1, 16'd0, 11'd1},  // R9
        '{1'b0, 1'b0, 1'b0, 16'd0, 11'd1},  // R11
        '{1'b0, 1'b0, 1'b1, 16'd0, 11'd0}   // R8
    };

    function automatic logic [31:0] mk(input logic fo, input logic [10:0] f,
                                       input logic fm, input logic [15:0] m);
        return {3'b000, fo, f, fm, m};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic b, input logic r);
        @(negedge clk);
        nd = a; fd = b; rd = r;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        nd = 0; fd = 0; rd = 0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 reset word", status, 32'h0);
        check("R10 pad bits after reset", {29'd0, status[31:29]}, 32'h0);

        for (int i = 0; i < 11; i++) begin
            step(VECS[i].a, VECS[i].b, VECS[i].r);
            check($sformatf("R2/R3/R4/R8/R9/R11 vector %0d", i), status,
                  mk(1'b0, VECS[i].f, 1'b0, VECS[i].m));
        end

        // R8: the word visible during the read cycle is the pre-clear value
        step(1, 1, 0);
        step(1, 0, 0);
        check("R8 before read", status, mk(0, 11'd1, 0, 16'd2));
        @(negedge clk);
        nd = 0; fd = 0; rd = 1;
        #1;
        check("R8 value during read cycle", status, mk(0, 11'd1, 0, 16'd2));
        @(posedge clk);
        #1;
        check("R8 cleared after read", status, 32'h0);

        // Saturation climb
        do_reset();
        for (int i = 0; i < 2047; i++) step(1, 1, 0);
        step(0, 0, 0);
        check("R3 fifo tally at max", status, mk(0, 11'h7FF, 0, 16'd2047));
        step(1, 1, 0);
        check("R6 fifo pinned and flagged", status, mk(1, 11'h7FF, 0, 16'd2048));
        for (int i = 0; i < 63487; i++) step(1, 0, 0);
        step(0, 0, 0);
        check("R2 desc tally at max, no flag", status, mk(1, 11'h7FF, 0, 16'hFFFF));
        step(1, 0, 0);
        check("R5 desc pinned and flagged", status, mk(1, 11'h7FF, 1, 16'hFFFF));
        step(1, 1, 0);
        step(1, 1, 0);
        step(0, 0, 0);
        check("R7 no wrap, flags sticky", status, mk(1, 11'h7FF, 1, 16'hFFFF));
        check("R10 pad bits at saturation", {29'd0, status[31:29]}, 32'h0);
        step(1, 1, 1);
        check("R9 read with both losses from saturation", status, mk(0, 11'd1, 0, 16'd1));
        step(0, 0, 1);
        check("R8 cleared from nonzero", status, 32'h0);
        step(0, 0, 0);
        check("R11 idle after clear", status, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule